// File: doc/BRIEF.md
# Segmented Thermometer Encoder for a Current-Cell RF DAC

This block sits between the digital amplitude path and an array of switched current cells in a radio-frequency DAC. It takes a 10-bit unsigned amplitude word and splits it into two segments. The four low bits become a 16-line thermometer code that drives cells of unit weight. The six high bits become a 64-line thermometer code that drives cells of sixteen times that weight. The total weight switched on therefore equals the amplitude value, and the coarse cells keep the array small enough to cover the wide amplitude swing of high peak-to-average signals.

A sample strobe captures the amplitude and a sign bit into one register, so both segments and the sign change on the same clock edge. After that register, a local-oscillator gate is ANDed into every enable line, so the cells switch at the oscillator rate. The sign bit chooses which of two differential output buses carries the enables. The other bus stays at zero. Current cells, bias-based power control and the analog mixing are outside this block.

Top module: `rfdac_seg_encoder`

## Requirements
- R1: After a synchronous active-low reset, all four enable buses are zero.
- R2: For a low-segment value v (amplitude bits 3:0), exactly unit lines 0 to v-1 of the active bus are set and all others are clear. Unit line 15 is never set.
- R3: For a high-segment value w (amplitude bits 9:4), exactly coarse lines 0 to w-1 of the active bus are set and all others are clear. Coarse line 63 is never set.
- R4: With the gate high, the number of set unit lines plus 16 times the number of set coarse lines equals the captured amplitude, for every amplitude from 0 to 1023.
- R5: The amplitude and sign are captured only in a cycle where the sample strobe is high. Changes on the amplitude or sign inputs without the strobe leave the outputs unchanged.
- R6: The outputs reflect a captured amplitude exactly one clock edge after the strobe. Both segments update on that same edge, and nothing changes before it.
- R7: While the oscillator gate is low, every line of all four buses is zero. This is combinational with no clock delay. When the gate returns high, the held codeword reappears without a new sample.
- R8: A captured sign of 0 routes the enables to the positive buses. A captured sign of 1 routes them to the negative buses.
- R9: The bus pair not selected by the captured sign is all zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 1 | Capture strobe for amplitude and sign |
| amp_i | input | 10 | Unsigned amplitude word |
| sign_i | input | 1 | Side select: 0 positive, 1 negative |
| lo_gate_i | input | 1 | Oscillator-rate gate, low forces all cells off |
| pos_unit_o | output | 16 | Unit-cell enables, positive side |
| pos_coarse_o | output | 64 | 16x-cell enables, positive side |
| neg_unit_o | output | 16 | Unit-cell enables, negative side |
| neg_coarse_o | output | 64 | 16x-cell enables, negative side |

## Verification
The assertions check the following on every cycle:
- the thermometer shape of both segments;
- that the top line of each segment stays clear;
- that the idle bus is zero;
- that a low gate blanks everything;
- that the weighted line count matches the amplitude captured one edge earlier;
- that outputs hold when no strobe occurred.

Only the bench scenarios can show the following:
- the exact line positions for each segment value;
- the full sweep over all 1024 amplitudes against an independently computed pattern;
- the absence of an early update before the capturing edge;
- that the held word returns after the gate is released.

// File: rtl/seg_enc_pkg.sv
// Package: shared constants and the side-select encoding for the
// segmented thermometer encoder. Assumes the fine segment width and
// coarse segment width together form the amplitude word.
package seg_enc_pkg;

    // Default split of the amplitude word
    localparam int FINE_BITS_DEF   = 4;
    localparam int COARSE_BITS_DEF = 6;

    // Side selection encoding (value of the sign bit)
    typedef enum logic {
        SIDE_POS = 1'b0,
        SIDE_NEG = 1'b1
    } side_e;

endpackage

// File: rtl/seg_therm_decode.sv
// Module: seg_therm_decode
// Converts an unsigned binary value into a thermometer code in which
// lines 0..value-1 are high. Purely combinational. Assumes IN_W is small
// enough that 2**IN_W lines is a practical width. Because the value is
// at most 2**IN_W-1, the top line can never be set.
module seg_therm_decode #(
    parameter  int IN_W  = 4,
    localparam int LINES = 1 << IN_W
) (
    input  logic [IN_W-1:0]  value_i,
    output logic [LINES-1:0] lines_o
);

    logic [31:0] value_ext;

    // Zero-extend the value once for the per-line comparisons
    assign value_ext = 32'(value_i);

    // One comparator per line: the line is on when its index is below the value
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines_o[i] = (value_ext > 32'(i));
    end

endmodule

// File: rtl/seg_capture_stage.sv
// Module: seg_capture_stage
// Holds the decoded fine lines, coarse lines and side select in a single
// register bank. All of them load together on the strobe, so the two
// segments never skew. Synchronous active-low reset clears every bit.
// Assumes the strobe is synchronous to clk.
module seg_capture_stage #(
    parameter int FINE_LINES   = 16,
    parameter int COARSE_LINES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [FINE_LINES-1:0]   fine_d_i,
    input  logic [COARSE_LINES-1:0] coarse_d_i,
    input  logic                    side_d_i,
    output logic [FINE_LINES-1:0]   fine_q_o,
    output logic [COARSE_LINES-1:0] coarse_q_o,
    output logic                    side_q_o
);

    // Capture the whole codeword and side together on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_q_o   <= '0;
            coarse_q_o <= '0;
            side_q_o   <= 1'b0;
        end else if (load_i) begin
            fine_q_o   <= fine_d_i;
            coarse_q_o <= coarse_d_i;
            side_q_o   <= side_d_i;
        end
    end

endmodule

// File: rtl/seg_side_steer.sv
// Module: seg_side_steer
// Applies the oscillator gate to a bank of registered enable lines. It
// then places the result on the positive or the negative bus according
// to the side select, and holds the other bus at zero. Combinational.
// Assumes the lines come straight from a register, so the gate is the
// only late-arriving input.
module seg_side_steer #(
    parameter int LINES = 16
) (
    input  logic [LINES-1:0] lines_i,
    input  logic             side_i,
    input  logic             gate_i,
    output logic [LINES-1:0] pos_o,
    output logic [LINES-1:0] neg_o
);

    import seg_enc_pkg::*;

    logic [LINES-1:0] gated;
    logic             to_pos;
    logic             to_neg;

    // Side decode from the registered sign
    assign to_pos = (side_e'(side_i) == SIDE_POS);
    assign to_neg = (side_e'(side_i) == SIDE_NEG);

    // Per-line gating and routing
    for (genvar i = 0; i < LINES; i++) begin : g_bit
        assign gated[i] = lines_i[i] & gate_i;
        assign pos_o[i] = gated[i] & to_pos;
        assign neg_o[i] = gated[i] & to_neg;
    end

endmodule

// File: rtl/rfdac_seg_encoder.sv
// Module: rfdac_seg_encoder (top)
// Splits an unsigned amplitude into a fine thermometer segment of unit
// cells and a coarse thermometer segment of cells weighted 2**FINE_BITS.
// It registers both segments with the sign on a sample strobe, then gates
// them with the oscillator enable and steers them to one differential side.
// Assumes amp_i and sign_i are stable in the cycle where sample_i is high.
module rfdac_seg_encoder #(
    parameter  int FINE_BITS    = seg_enc_pkg::FINE_BITS_DEF,
    parameter  int COARSE_BITS  = seg_enc_pkg::COARSE_BITS_DEF,
    localparam int AMP_W        = FINE_BITS + COARSE_BITS,
    localparam int FINE_LINES   = 1 << FINE_BITS,
    localparam int COARSE_LINES = 1 << COARSE_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_i,
    input  logic [AMP_W-1:0]        amp_i,
    input  logic                    sign_i,
    input  logic                    lo_gate_i,
    output logic [FINE_LINES-1:0]   pos_unit_o,
    output logic [COARSE_LINES-1:0] pos_coarse_o,
    output logic [FINE_LINES-1:0]   neg_unit_o,
    output logic [COARSE_LINES-1:0] neg_coarse_o
);

    logic [FINE_BITS-1:0]    fine_val;
    logic [COARSE_BITS-1:0]  coarse_val;
    logic [FINE_LINES-1:0]   fine_d;
    logic [COARSE_LINES-1:0] coarse_d;
    logic [FINE_LINES-1:0]   fine_q;
    logic [COARSE_LINES-1:0] coarse_q;
    logic                    side_q;

    // Segment split of the amplitude word
    assign fine_val   = amp_i[FINE_BITS-1:0];
    assign coarse_val = amp_i[AMP_W-1:FINE_BITS];

    // Fine segment decode
    seg_therm_decode #(.IN_W(FINE_BITS)) u_fine_dec (
        .value_i (fine_val),
        .lines_o (fine_d)
    );

    // Coarse segment decode
    seg_therm_decode #(.IN_W(COARSE_BITS)) u_coarse_dec (
        .value_i (coarse_val),
        .lines_o (coarse_d)
    );

    // Single register bank for both segments and the sign
    seg_capture_stage #(
        .FINE_LINES   (FINE_LINES),
        .COARSE_LINES (COARSE_LINES)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sample_i),
        .fine_d_i   (fine_d),
        .coarse_d_i (coarse_d),
        .side_d_i   (sign_i),
        .fine_q_o   (fine_q),
        .coarse_q_o (coarse_q),
        .side_q_o   (side_q)
    );

    // Gate and steer the fine segment
    seg_side_steer #(.LINES(FINE_LINES)) u_fine_steer (
        .lines_i (fine_q),
        .side_i  (side_q),
        .gate_i  (lo_gate_i),
        .pos_o   (pos_unit_o),
        .neg_o   (neg_unit_o)
    );

    // Gate and steer the coarse segment
    seg_side_steer #(.LINES(COARSE_LINES)) u_coarse_steer (
        .lines_i (coarse_q),
        .side_i  (side_q),
        .gate_i  (lo_gate_i),
        .pos_o   (pos_coarse_o),
        .neg_o   (neg_coarse_o)
    );

endmodule

// File: rtl/seg_enc_checker.sv
// Module: seg_enc_checker
// Port-level properties of rfdac_seg_encoder, attached through bind.
// A local flag marks cycles whose previous cycle was already out of
// reset, so that $past refers only to post-reset history.
module seg_enc_checker #(
    parameter  int FINE_BITS    = 4,
    parameter  int COARSE_BITS  = 6,
    localparam int AMP_W        = FINE_BITS + COARSE_BITS,
    localparam int FINE_LINES   = 1 << FINE_BITS,
    localparam int COARSE_LINES = 1 << COARSE_BITS
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_i,
    input logic [AMP_W-1:0]        amp_i,
    input logic                    sign_i,
    input logic                    lo_gate_i,
    input logic [FINE_LINES-1:0]   pos_unit_o,
    input logic [COARSE_LINES-1:0] pos_coarse_o,
    input logic [FINE_LINES-1:0]   neg_unit_o,
    input logic [COARSE_LINES-1:0] neg_coarse_o
);

    logic                    hist_ok;
    logic [FINE_LINES-1:0]   any_unit;
    logic [COARSE_LINES-1:0] any_coarse;
    logic [FINE_LINES:0]     unit_ext;
    logic [COARSE_LINES:0]   coarse_ext;
    int                      weight;

    // Track whether the previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    assign any_unit   = pos_unit_o | neg_unit_o;
    assign any_coarse = pos_coarse_o | neg_coarse_o;
    assign unit_ext   = {1'b0, any_unit};
    assign coarse_ext = {1'b0, any_coarse};
    assign weight     = $countones(any_unit) + FINE_LINES * $countones(any_coarse);

    // R1: first cycle after reset release shows empty buses
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hist_ok |-> (any_unit == '0 && any_coarse == '0));

    // R2: fine segment is a thermometer with the top line clear
    p_unit_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (((unit_ext + 1'b1) & unit_ext) == '0) && !any_unit[FINE_LINES-1]);

    // R3: coarse segment is a thermometer with the top line clear
    p_coarse_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((coarse_ext + 1'b1) & coarse_ext) == '0) && !any_coarse[COARSE_LINES-1]);

    // R4 and R6: weight one edge after a strobe equals the sampled amplitude
    p_weight_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(sample_i) && lo_gate_i) |-> (weight == int'($past(amp_i))));

    // R5: without a strobe, an ungated codeword holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !$past(sample_i) && lo_gate_i && $past(lo_gate_i)) |->
        ($stable(pos_unit_o) && $stable(pos_coarse_o) &&
         $stable(neg_unit_o) && $stable(neg_coarse_o)));

    // R7: a low gate blanks every line
    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_gate_i |-> (any_unit == '0 && any_coarse == '0));

    // R8: sampled sign picks the side carrying a non-zero codeword
    p_sign_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(sample_i) && lo_gate_i && ($past(amp_i) != '0)) |->
        ($past(sign_i) ? (pos_unit_o == '0 && pos_coarse_o == '0)
                       : (neg_unit_o == '0 && neg_coarse_o == '0)));

    // R9: never both sides active
    p_side_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos_unit_o == '0) && (pos_coarse_o == '0)) ||
        ((neg_unit_o == '0) && (neg_coarse_o == '0)));

endmodule

bind rfdac_seg_encoder seg_enc_checker #(
    .FINE_BITS   (FINE_BITS),
    .COARSE_BITS (COARSE_BITS)
) u_seg_enc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .amp_i        (amp_i),
    .sign_i       (sign_i),
    .lo_gate_i    (lo_gate_i),
    .pos_unit_o   (pos_unit_o),
    .pos_coarse_o (pos_coarse_o),
    .neg_unit_o   (neg_unit_o),
    .neg_coarse_o (neg_coarse_o)
);

// File: tb/test_rfdac_seg_encoder.sv
// Directed bench for rfdac_seg_encoder: one task per scenario, each
// checking its own results at the falling edge.
module test_rfdac_seg_encoder;

    localparam int FB = 4;
    localparam int CB = 6;
    localparam int AW = FB + CB;
    localparam int FL = 1 << FB;
    localparam int CL = 1 << CB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_i = 1'b0;
    logic [AW-1:0] amp_i = '0;
    logic          sign_i = 1'b0;
    logic          lo_gate_i = 1'b1;
    logic [FL-1:0] pos_unit_o, neg_unit_o;
    logic [CL-1:0] pos_coarse_o, neg_coarse_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    rfdac_seg_encoder #(.FINE_BITS(FB), .COARSE_BITS(CB)) i_rfdac_seg_encoder (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .amp_i(amp_i),
        .sign_i(sign_i), .lo_gate_i(lo_gate_i),
        .pos_unit_o(pos_unit_o), .pos_coarse_o(pos_coarse_o),
        .neg_unit_o(neg_unit_o), .neg_coarse_o(neg_coarse_o)
    );

    function automatic logic [FL-1:0] therm_f(input int v);
        logic [FL-1:0] r = '0;
        for (int i = 0; i < FL; i++) r[i] = (i < v);
        return r;
    endfunction

    function automatic logic [CL-1:0] therm_c(input int v);
        logic [CL-1:0] r = '0;
        for (int i = 0; i < CL; i++) r[i] = (i < v);
        return r;
    endfunction

    // Compare all four buses against the model for (amp, sign, gate)
    task automatic expect_out(input string req, input int amp, input logic sgn, input logic gate);
        logic [FL-1:0] eu;
        logic [CL-1:0] ec;
        logic [FL-1:0] pu, nu;
        logic [CL-1:0] pc, nc;
        eu = gate ? therm_f(amp % FL) : '0;
        ec = gate ? therm_c(amp / FL) : '0;
        pu = sgn ? '0 : eu;
        pc = sgn ? '0 : ec;
        nu = sgn ? eu : '0;
        nc = sgn ? ec : '0;
        n_checks++;
        if (pos_unit_o !== pu || pos_coarse_o !== pc || neg_unit_o !== nu || neg_coarse_o !== nc) begin
            n_fail++;
            $display("FAIL %s amp=%0d: got pu=%h pc=%h nu=%h nc=%h exp pu=%h pc=%h nu=%h nc=%h",
                     req, amp, pos_unit_o, pos_coarse_o, neg_unit_o, neg_coarse_o, pu, pc, nu, nc);
        end
    endtask

    // Drive one strobed sample; returns at the falling edge after capture
    task automatic apply(input int amp, input logic sgn);
        @(negedge clk);
        amp_i = AW'(amp);
        sign_i = sgn;
        sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_out("R1", 0, 1'b0, 1'b1);
    endtask

    task automatic t_fine;
        for (int v = 0; v < FL; v++) begin
            apply(v, 1'b0);
            expect_out("R2", v, 1'b0, 1'b1);
        end
    endtask

    task automatic t_coarse;
        for (int w = 0; w < CL; w++) begin
            apply(w * FL + 5, 1'b0);
            expect_out("R3", w * FL + 5, 1'b0, 1'b1);
        end
    endtask

    task automatic t_full;
        for (int a = 0; a < (1 << AW); a++) begin
            int s;
            apply(a, 1'(a[3]));
            s = $countones(pos_unit_o | neg_unit_o) + FL * $countones(pos_coarse_o | neg_coarse_o);
            n_checks++;
            if (s != a) begin
                n_fail++;
                $display("FAIL R4 weight got %0d exp %0d", s, a);
            end
            expect_out("R4", a, 1'(a[3]), 1'b1);
        end
    endtask

    task automatic t_hold;
        apply(300, 1'b0);
        @(negedge clk);
        amp_i = 10'd1000;
        sign_i = 1'b1;
        repeat (3) @(negedge clk);
        expect_out("R5", 300, 1'b0, 1'b1);
    endtask

    task automatic t_latency;
        apply(17, 1'b0);
        @(negedge clk);
        amp_i = 10'd1022;
        sign_i = 1'b0;
        sample_i = 1'b1;
        #1;
        expect_out("R6", 17, 1'b0, 1'b1);      // before the capturing edge
        @(negedge clk);
        sample_i = 1'b0;
        expect_out("R6", 1022, 1'b0, 1'b1);    // both segments after one edge
    endtask

    task automatic t_gate;
        apply(1023, 1'b0);
        @(negedge clk);
        lo_gate_i = 1'b0;
        #1;
        expect_out("R7", 1023, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R7", 1023, 1'b0, 1'b0);
        lo_gate_i = 1'b1;
        #1;
        expect_out("R7", 1023, 1'b0, 1'b1);
    endtask

    task automatic t_sign;
        apply(777, 1'b1);
        expect_out("R8", 777, 1'b1, 1'b1);
        apply(777, 1'b0);
        expect_out("R8", 777, 1'b0, 1'b1);
        apply(250, 1'b1);
        n_checks++;
        if (pos_unit_o !== '0 || pos_coarse_o !== '0) begin
            n_fail++;
            $display("FAIL R9 idle side pu=%h pc=%h exp 0", pos_unit_o, pos_coarse_o);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fine();
        t_coarse();
        t_hold();
        t_latency();
        t_gate();
        t_sign();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule